// File: doc/BRIEF.md
# Microstepped Multicycle Load/Store Processor Core

This block is a 32-bit load/store processor that executes one instruction at a time as a fixed series of register-transfer steps, one step per clock. A small step selector turns the current opcode and step number into a single micro-operation. That operation moves data between the program counter, instruction register, memory address register (MAR), memory data register (MDR), a scratch register T and a 32-entry register file.

The core talks to one single-port, word-addressed memory with no wait states. The read data is expected in the same cycle that the address is presented. A write is a single-cycle strobe carrying the address and the data.

Every instruction starts with the same three-step fetch. Its total clock count is fixed by its addressing mode. This lets a system model count execution time exactly. A halt instruction, or any unassigned opcode, stops the core until reset.

Top module: `stepcpu_core`

## Requirements
- R1: Every instruction starts with a three-clock fetch. The first step copies PC into MAR. The second reads memory at MAR into MDR and adds one to PC. The third copies MDR into the instruction register. Execution proceeds in PC order unless a jump changes PC.
- R2: Field positions in the instruction word:
  - The opcode is bits 31:27 and r1 is bits 26:22.
  - r2 is bits 21:17 and r3 is bits 16:12.
  - The 17-bit displacement is bits 16:0 and is sign-extended.
  - The 22-bit address is bits 21:0 and is zero-extended.
- R3: Loads write R[r1] from one of four sources. Opcode 0 reads memory at the address field. Opcode 1 reads memory at R[r2]+displacement. Opcode 2 reads memory at R[r2]+R[r3]. Opcode 3 writes the sign-extended displacement directly.
- R4: Stores copy R[r1] into MDR and then write it to memory with exactly one write-strobe cycle. Opcode 4 writes at the address field, opcode 5 at R[r2]+displacement and opcode 6 at R[r2]+R[r3].
- R5: Each ALU operation computes into T and then writes T to R[r1]. Even opcodes take R[r2] and R[r3]; the next odd opcode takes R[r2] and the displacement. The pairs are add 10/11, subtract 12/13, multiply 14/15, unsigned divide 16/17, and 18/19, or 20/21 and xor 22/23.
  - Multiply keeps the low 32 bits.
  - Divide by zero yields zero.
- R6: Opcode 24 writes R[r2] shifted left by one to R[r1]. Opcode 25 writes R[r2] shifted right by one, logically, to R[r1].
- R7: The zero and negative flags are updated only when an ALU or shift result is written, and both clear on reset. Opcode 7 loads PC from the address field when the condition chosen by r1 holds:
  - 0: always.
  - 1: zero.
  - 2: not zero.
  - 3: negative.
  - 4: not negative.
  - 5 to 31: never.
- R8: Opcode 8 writes the already-incremented PC into R[r1] and then loads PC from the address field. Opcode 9 loads PC from R[r1].
- R9: Total clocks per instruction, fetch included:
  - Address-field load and store: 6.
  - Displacement and indexed load and store: 7.
  - Immediate load: 4.
  - Conditional jump and register jump: 4 each.
  - Jump-and-link: 5.
  - ALU and shift operations: 5.
  - Halt: 4.
- R10: Synchronous active-low reset clears PC, MAR and all registers, and deasserts halted and the write strobe. Opcode 26 and the unassigned opcodes 27 to 31 set halted in their fourth clock. After that no further write or address change occurs until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | ADDR_W | Word address, driven from MAR |
| mem_rdata | input | 32 | Read data, valid in the same cycle as the address |
| mem_wdata | output | 32 | Write data, driven from MDR |
| mem_we | output | 1 | Single-cycle write strobe |
| halted | output | 1 | Set by a halt or unassigned opcode; cleared by reset |

## Verification
The in-RTL assertions check, on every cycle:
- The fetch read uses PC as its address and is followed by an increment of exactly one.
- Every write strobe comes straight after the MDR was loaded from R[r1], and carries that value.
- The flags stay unchanged outside result write-back.
- A halted core stays halted without writing.
- A seven-step instruction ends at its last step.

The arithmetic results, address arithmetic, sign and zero extension, jump conditions, link value and exact clock counts can only be shown by the bench's programs. The bench runs each instruction between fixed preload and store-out code and compares the stored results and the clocks to halt against values worked out from the requirements.

// File: rtl/stepcpu_pkg.sv
// Shared definitions for the microstepped core: word width, opcode
// numbering and the micro-operation codes issued by the step selector.
package stepcpu_pkg;

    localparam int XLEN = 32;

    // Opcode numbering; values 27..31 are unassigned and halt the core.
    typedef enum logic [4:0] {
        OP_LD_ABS = 5'd0,  OP_LD_DSP = 5'd1,  OP_LD_IDX = 5'd2,  OP_LD_IMM = 5'd3,
        OP_ST_ABS = 5'd4,  OP_ST_DSP = 5'd5,  OP_ST_IDX = 5'd6,
        OP_JCOND  = 5'd7,  OP_JLINK  = 5'd8,  OP_JREG   = 5'd9,
        OP_ADD_R  = 5'd10, OP_ADD_I  = 5'd11, OP_SUB_R  = 5'd12, OP_SUB_I  = 5'd13,
        OP_MUL_R  = 5'd14, OP_MUL_I  = 5'd15, OP_DIV_R  = 5'd16, OP_DIV_I  = 5'd17,
        OP_AND_R  = 5'd18, OP_AND_I  = 5'd19, OP_OR_R   = 5'd20, OP_OR_I   = 5'd21,
        OP_XOR_R  = 5'd22, OP_XOR_I  = 5'd23, OP_SHL1   = 5'd24, OP_SHR1   = 5'd25,
        OP_HALT   = 5'd26
    } opc_e;

    // One register transfer per clock.
    typedef enum logic [4:0] {
        U_FMAR,    // MAR <- PC
        U_FRD,     // MDR <- mem[MAR], PC <- PC + 1
        U_FIR,     // IR <- MDR
        U_MAR_ADS, // MAR <- address field
        U_MAR_T,   // MAR <- T
        U_T_DSP,   // T <- R[r2] + displacement
        U_T_IDX,   // T <- R[r2] + R[r3]
        U_MDR_RD,  // MDR <- mem[MAR]
        U_MDR_REG, // MDR <- R[r1]
        U_MEM_WR,  // mem[MAR] <- MDR
        U_REG_MDR, // R[r1] <- MDR
        U_REG_DSP, // R[r1] <- displacement
        U_JCOND,   // PC <- address field if condition holds
        U_LINK,    // R[r1] <- PC
        U_PC_ADS,  // PC <- address field
        U_PC_REG,  // PC <- R[r1]
        U_T_ALU,   // T <- ALU result
        U_REG_T,   // R[r1] <- T, flags from T
        U_HALT     // stop fetching
    } uop_e;

endpackage

// File: rtl/stepcpu_useq.sv
// Step selector: maps (opcode, step number) to the micro-operation for this
// clock and flags the final step of the instruction.
// Assumes steps 0..2 are the fetch and that the step counter restarts at 0
// after a step flagged last.
module stepcpu_useq
    import stepcpu_pkg::*;
#(
    parameter int STEP_W = 3
) (
    input  logic [4:0]        op,
    input  logic [STEP_W-1:0] step,
    output uop_e              uop,
    output logic              last
);

    localparam int FETCH_N = 3;

    logic [STEP_W-1:0] k;
    assign k = step - STEP_W'(FETCH_N);

    // Pick the micro-operation for the current step.
    always_comb begin
        uop = U_HALT;
        if (step == STEP_W'(0)) begin
            uop = U_FMAR;
        end else if (step == STEP_W'(1)) begin
            uop = U_FRD;
        end else if (step == STEP_W'(2)) begin
            uop = U_FIR;
        end else begin
            case (opc_e'(op))
                OP_LD_ABS: uop = (k == 0) ? U_MAR_ADS : (k == 1) ? U_MDR_RD : U_REG_MDR;
                OP_LD_DSP: uop = (k == 0) ? U_T_DSP : (k == 1) ? U_MAR_T :
                                 (k == 2) ? U_MDR_RD : U_REG_MDR;
                OP_LD_IDX: uop = (k == 0) ? U_T_IDX : (k == 1) ? U_MAR_T :
                                 (k == 2) ? U_MDR_RD : U_REG_MDR;
                OP_LD_IMM: uop = U_REG_DSP;
                OP_ST_ABS: uop = (k == 0) ? U_MAR_ADS : (k == 1) ? U_MDR_REG : U_MEM_WR;
                OP_ST_DSP: uop = (k == 0) ? U_T_DSP : (k == 1) ? U_MAR_T :
                                 (k == 2) ? U_MDR_REG : U_MEM_WR;
                OP_ST_IDX: uop = (k == 0) ? U_T_IDX : (k == 1) ? U_MAR_T :
                                 (k == 2) ? U_MDR_REG : U_MEM_WR;
                OP_JCOND:  uop = U_JCOND;
                OP_JLINK:  uop = (k == 0) ? U_LINK : U_PC_ADS;
                OP_JREG:   uop = U_PC_REG;
                OP_ADD_R, OP_ADD_I, OP_SUB_R, OP_SUB_I, OP_MUL_R, OP_MUL_I,
                OP_DIV_R, OP_DIV_I, OP_AND_R, OP_AND_I, OP_OR_R, OP_OR_I,
                OP_XOR_R, OP_XOR_I, OP_SHL1, OP_SHR1:
                           uop = (k == 0) ? U_T_ALU : U_REG_T;
                default:   uop = U_HALT;
            endcase
        end
    end

    // Mark the micro-operations that close an instruction.
    always_comb begin
        last = (uop inside {U_REG_MDR, U_REG_DSP, U_MEM_WR, U_JCOND,
                            U_PC_ADS, U_PC_REG, U_REG_T, U_HALT});
    end

endmodule

// File: rtl/stepcpu_alu.sv
// Combinational ALU. Register forms take rb; immediate forms take imm.
// Multiply keeps the low W bits. Divide is unsigned and gives zero for a zero
// divisor. Shifts move by one bit, and the right shift is logical.
module stepcpu_alu
    import stepcpu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [4:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] rb,
    input  logic [W-1:0] imm,
    output logic [W-1:0] y
);

    logic [W-1:0] b;

    // Choose the second operand: odd opcodes in the ALU range use the immediate.
    always_comb begin
        b = (op[0] && op >= 5'(OP_ADD_I) && op <= 5'(OP_XOR_I)) ? imm : rb;
    end

    // Compute the result for the selected operation.
    always_comb begin
        case (opc_e'(op))
            OP_ADD_R, OP_ADD_I: y = a + b;
            OP_SUB_R, OP_SUB_I: y = a - b;
            OP_MUL_R, OP_MUL_I: y = a * b;
            OP_DIV_R, OP_DIV_I: y = (b == '0) ? '0 : a / b;
            OP_AND_R, OP_AND_I: y = a & b;
            OP_OR_R,  OP_OR_I:  y = a | b;
            OP_XOR_R, OP_XOR_I: y = a ^ b;
            OP_SHL1:            y = a << 1;
            OP_SHR1:            y = a >> 1;
            default:            y = '0;
        endcase
    end

endmodule

// File: rtl/stepcpu_regfile.sv
// General register file: three combinational read ports and one synchronous
// write port. All entries clear on synchronous active-low reset.
module stepcpu_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    input  logic [AW-1:0] ra3,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    output logic [W-1:0]  rd3,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs [NREG];

    // Clear on reset, otherwise write one entry when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];
    assign rd3 = regs[ra3];

endmodule

// File: rtl/stepcpu_core.sv
// Multicycle load/store core. Each instruction runs as a fixed list of
// register transfers chosen by stepcpu_useq, one per clock.
// Assumes a single-port word memory whose read data is valid in the same cycle
// as mem_addr, and which captures mem_wdata at the clock edge that ends a
// mem_we cycle. ADDR_W must be below 32; NREG must be a power of two up to 32.
module stepcpu_core
    import stepcpu_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int NREG   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic [XLEN-1:0]   mem_wdata,
    output logic              mem_we,
    output logic              halted
);

    localparam int RAW    = $clog2(NREG);
    localparam int STEP_W = 3;
    localparam int MAXSTP = 6;

    logic [ADDR_W-1:0] pc, mar;
    logic [XLEN-1:0]   ir, mdr, t;
    logic [STEP_W-1:0] step;
    logic              halt, zf, nf;
    uop_e              uop;
    logic              last;
    logic [XLEN-1:0]   rd1, rd2, rd3, rf_wd, alu_y, disp_x, ads_x;
    logic              rf_we, cond_ok;

    assign disp_x = {{(XLEN-17){ir[16]}}, ir[16:0]};
    assign ads_x  = {{(XLEN-22){1'b0}}, ir[21:0]};

    stepcpu_useq #(.STEP_W(STEP_W)) useq_i (
        .op(ir[31:27]), .step(step), .uop(uop), .last(last)
    );

    stepcpu_alu #(.W(XLEN)) alu_i (
        .op(ir[31:27]), .a(rd2), .rb(rd3), .imm(disp_x), .y(alu_y)
    );

    stepcpu_regfile #(.NREG(NREG), .W(XLEN)) rf_i (
        .clk(clk), .rst_n(rst_n),
        .ra1(ir[22 +: RAW]), .ra2(ir[17 +: RAW]), .ra3(ir[12 +: RAW]),
        .rd1(rd1), .rd2(rd2), .rd3(rd3),
        .we(rf_we), .wa(ir[22 +: RAW]), .wd(rf_wd)
    );

    // Evaluate the jump condition selected by the r1 field.
    always_comb begin
        case (ir[26:22])
            5'd0:    cond_ok = 1'b1;
            5'd1:    cond_ok = zf;
            5'd2:    cond_ok = !zf;
            5'd3:    cond_ok = nf;
            5'd4:    cond_ok = !nf;
            default: cond_ok = 1'b0;
        endcase
    end

    // Select the register-file write enable and data for this step.
    always_comb begin
        rf_we = !halt && (uop inside {U_REG_MDR, U_REG_DSP, U_LINK, U_REG_T});
        case (uop)
            U_REG_MDR: rf_wd = mdr;
            U_REG_DSP: rf_wd = disp_x;
            U_LINK:    rf_wd = XLEN'(pc);
            default:   rf_wd = t;
        endcase
    end

    // Carry out the current micro-operation and advance the step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc   <= '0;
            mar  <= '0;
            ir   <= '0;
            mdr  <= '0;
            t    <= '0;
            step <= '0;
            halt <= 1'b0;
            zf   <= 1'b0;
            nf   <= 1'b0;
        end else if (!halt) begin
            step <= last ? '0 : step + 1'b1;
            case (uop)
                U_FMAR:    mar <= pc;
                U_FRD:     begin mdr <= mem_rdata; pc <= pc + 1'b1; end
                U_FIR:     ir  <= mdr;
                U_MAR_ADS: mar <= ads_x[ADDR_W-1:0];
                U_MAR_T:   mar <= t[ADDR_W-1:0];
                U_T_DSP:   t   <= rd2 + disp_x;
                U_T_IDX:   t   <= rd2 + rd3;
                U_MDR_RD:  mdr <= mem_rdata;
                U_MDR_REG: mdr <= rd1;
                U_JCOND:   if (cond_ok) pc <= ads_x[ADDR_W-1:0];
                U_PC_ADS:  pc  <= ads_x[ADDR_W-1:0];
                U_PC_REG:  pc  <= rd1[ADDR_W-1:0];
                U_T_ALU:   t   <= alu_y;
                U_REG_T:   begin zf <= (t == '0); nf <= t[XLEN-1]; end
                U_HALT:    halt <= 1'b1;
                default:   ;
            endcase
        end
    end

    assign mem_addr  = mar;
    assign mem_wdata = mdr;
    assign mem_we    = !halt && (uop == U_MEM_WR);
    assign halted    = halt;

    AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n) (!halt && uop == U_FRD) |-> (mem_addr == pc)) else $error("fetch read not at PC"); // R1
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n) (!halt && uop == U_FRD) |=> (pc == $past(pc) + 1'b1)) else $error("PC did not advance by one"); // R1
    AST_STORE_SRC: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> ($past(uop) == U_MDR_REG && mem_wdata == $past(rd1))) else $error("write data not taken from R[r1]"); // R4
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!halt && uop != U_REG_T) |=> $stable({zf, nf})) else $error("flags changed outside write-back"); // R7
    AST_SEQ_END: assert property (@(posedge clk) disable iff (!rst_n) (!halt && step == STEP_W'(MAXSTP)) |-> last) else $error("sequence longer than seven clocks"); // R9
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) halt |=> (halt && !mem_we && $stable(mem_addr))) else $error("activity while halted"); // R10

endmodule

// File: tb/stepcpu_core_tb_top.sv
`timescale 1ns/1ps
// Bench for stepcpu_core: a vector table of single instructions placed between
// fixed preload and store-out code, followed by directed programs.
module stepcpu_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [21:0] mem_addr;
    logic [31:0] mem_rdata, mem_wdata;
    logic        mem_we, halted;

    logic [31:0] mem [256];
    int nchk = 0;
    int nerr = 0;
    int wcnt = 0;

    localparam logic [31:0] SENT = 32'hDEADBEEF;
    localparam logic [31:0] DATA = 32'hCAFEF00D;
    localparam logic [31:0] HALT = {5'd26, 27'd0};

    always #2 clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:0]];

    stepcpu_core dut_i (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .halted(halted)
    );

    typedef struct packed {
        logic [31:0] ins;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp;
        logic [7:0]  chk;
        logic [3:0]  clks;
        logic        skip;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    // The instruction under test sits at address 2. R2 = mem[100] and R3 = mem[101]
    // are preloaded; R1 is then stored to 102 before the halt at 4.
    localparam vec_t VECS [NV] = '{
        '{{5'd10, 5'd1, 5'd2, 5'd3, 12'd0}, 32'd5, 32'd7, 32'd12, 8'd102, 4'd5, 1'b0, 4'd5},            // R5 add
        '{{5'd12, 5'd1, 5'd2, 5'd3, 12'd0}, 32'd5, 32'd7, 32'hFFFFFFFE, 8'd102, 4'd5, 1'b0, 4'd5},      // R5 sub
        '{{5'd11, 5'd1, 5'd2, 17'h1FFF1}, 32'd10, 32'd0, 32'hFFFFFFFB, 8'd102, 4'd5, 1'b0, 4'd2},       // R2 disp sign extension
        '{{5'd13, 5'd1, 5'd2, 17'd4}, 32'd10, 32'd0, 32'd6, 8'd102, 4'd5, 1'b0, 4'd5},                  // R5 sub imm
        '{{5'd15, 5'd1, 5'd2, 17'h1FFFD}, 32'd6, 32'd0, 32'hFFFFFFEE, 8'd102, 4'd5, 1'b0, 4'd5},        // R5 mul imm
        '{{5'd14, 5'd1, 5'd2, 5'd3, 12'd0}, 32'h00010000, 32'h00010003, 32'h00030000, 8'd102, 4'd5, 1'b0, 4'd5}, // R5 low half
        '{{5'd16, 5'd1, 5'd2, 5'd3, 12'd0}, 32'd100, 32'd7, 32'd14, 8'd102, 4'd5, 1'b0, 4'd5},          // R5 div
        '{{5'd16, 5'd1, 5'd2, 5'd3, 12'd0}, 32'd100, 32'd0, 32'd0, 8'd102, 4'd5, 1'b0, 4'd5},           // R5 div by zero
        '{{5'd17, 5'd1, 5'd2, 17'd0}, 32'd55, 32'd0, 32'd0, 8'd102, 4'd5, 1'b0, 4'd5},                  // R5 div imm zero
        '{{5'd19, 5'd1, 5'd2, 17'h000FF}, 32'h0000F0F0, 32'd0, 32'h000000F0, 8'd102, 4'd5, 1'b0, 4'd5}, // R5 and imm
        '{{5'd20, 5'd1, 5'd2, 5'd3, 12'd0}, 32'h00001200, 32'h00000034, 32'h00001234, 8'd102, 4'd5, 1'b0, 4'd5}, // R5 or
        '{{5'd23, 5'd1, 5'd2, 17'h1FFFF}, 32'hFFFF0000, 32'd0, 32'h0000FFFF, 8'd102, 4'd5, 1'b0, 4'd5}, // R5 xor imm
        '{{5'd24, 5'd1, 5'd2, 17'd0}, 32'h80000001, 32'd0, 32'h00000002, 8'd102, 4'd5, 1'b0, 4'd6},     // R6 shl
        '{{5'd25, 5'd1, 5'd2, 17'd0}, 32'h80000000, 32'd0, 32'h40000000, 8'd102, 4'd5, 1'b0, 4'd6},     // R6 shr logical
        '{{5'd3, 5'd1, 5'd0, 17'h1FF9C}, 32'd0, 32'd0, 32'hFFFFFF9C, 8'd102, 4'd4, 1'b0, 4'd3},         // R3 immediate
        '{{5'd0, 5'd1, 22'd103}, 32'd0, 32'd0, DATA, 8'd102, 4'd6, 1'b0, 4'd3},                         // R3 absolute
        '{{5'd1, 5'd1, 5'd2, 17'd3}, 32'd100, 32'd0, DATA, 8'd102, 4'd7, 1'b0, 4'd3},                   // R3 displacement
        '{{5'd2, 5'd1, 5'd2, 5'd3, 12'd0}, 32'd100, 32'd3, DATA, 8'd102, 4'd7, 1'b0, 4'd3},             // R3 indexed
        '{{5'd4, 5'd2, 22'd104}, 32'h11223344, 32'd0, 32'h11223344, 8'd104, 4'd6, 1'b0, 4'd4},          // R4 absolute
        '{{5'd5, 5'd2, 5'd3, 17'd4}, 32'd55, 32'd100, 32'd55, 8'd104, 4'd7, 1'b0, 4'd4},                // R4 displacement
        '{{5'd6, 5'd2, 5'd3, 5'd2, 12'd0}, 32'd4, 32'd100, 32'd4, 8'd104, 4'd7, 1'b0, 4'd4},            // R4 indexed
        '{{5'd8, 5'd1, 22'd3}, 32'd0, 32'd0, 32'd3, 8'd102, 4'd5, 1'b0, 4'd8},                          // R8 link
        '{{5'd9, 5'd2, 22'd0}, 32'd4, 32'd0, SENT, 8'd102, 4'd4, 1'b1, 4'd8},                           // R8 register jump
        '{{5'd7, 5'd0, 22'd4}, 32'd0, 32'd0, SENT, 8'd102, 4'd4, 1'b1, 4'd7},                           // R7 always
        '{{5'd7, 5'd1, 22'd4}, 32'd0, 32'd0, 32'd0, 8'd102, 4'd4, 1'b0, 4'd7}                           // R7 zero after reset
    };

    function automatic logic [31:0] enc_l(int op, int r1, int ads);
        return {op[4:0], r1[4:0], ads[21:0]};
    endfunction

    function automatic logic [31:0] enc_d(int op, int r1, int r2, int disp);
        return {op[4:0], r1[4:0], r2[4:0], disp[16:0]};
    endfunction

    function automatic logic [31:0] enc_x(int op, int r1, int r2, int r3);
        return {op[4:0], r1[4:0], r2[4:0], r3[4:0], 12'd0};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 32'd0;
        mem[102] = SENT;
        mem[103] = DATA;
        mem[104] = SENT;
    endtask

    // Reset, release, then count clocks until halted; apply memory writes.
    task automatic run_prog(output int cyc);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
        wcnt = 0;
        for (int n = 0; n < 400; n++) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (halted) break;
            if (mem_we) begin
                mem[mem_addr[7:0]] = mem_wdata;
                wcnt++;
            end
        end
    endtask

    // Flag program: R1 = R2 - R3, then a conditional jump to the halt at 5.
    task automatic flag_case(input int a, input int b, input int cond, input logic taken, input logic [31:0] exp, input string tag);
        int cyc;
        clear_mem();
        mem[0] = enc_l(0, 2, 100);
        mem[1] = enc_l(0, 3, 101);
        mem[2] = enc_x(12, 1, 2, 3);
        mem[3] = enc_l(7, cond, 5);
        mem[4] = enc_l(4, 1, 102);
        mem[5] = HALT;
        mem[100] = a;
        mem[101] = b;
        run_prog(cyc);
        check({tag, " result"}, mem[102], exp);
        check({tag, " clocks"}, cyc, taken ? 25 : 31);
    endtask

    initial begin
        #(4 * 200000);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        int cyc;
        logic [21:0] held;
        int quiet;

        // R10: reset state at the ports.
        clear_mem();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R10 reset halted", halted, 1'b0);
        check("R10 reset strobe", mem_we, 1'b0);
        check("R10 reset address", mem_addr, 22'd0);

        // Vector table: every instruction class with clocks and result.
        for (int v = 0; v < NV; v++) begin
            clear_mem();
            mem[0] = enc_l(0, 2, 100);
            mem[1] = enc_l(0, 3, 101);
            mem[2] = VECS[v].ins;
            mem[3] = enc_l(4, 1, 102);
            mem[4] = HALT;
            mem[100] = VECS[v].a;
            mem[101] = VECS[v].b;
            run_prog(cyc);
            check($sformatf("R%0d vector %0d result", VECS[v].req, v), mem[VECS[v].chk], VECS[v].exp);
            check($sformatf("R9 vector %0d clocks", v), cyc, 32'(VECS[v].clks) + (VECS[v].skip ? 16 : 22));
        end

        // R7: flags from a subtract steer the conditional jump.
        flag_case(7, 9, 3, 1'b1, SENT, "R7 negative taken");
        flag_case(7, 9, 4, 1'b0, 32'hFFFFFFFE, "R7 nonnegative not taken");
        flag_case(7, 9, 2, 1'b1, SENT, "R7 nonzero taken");
        flag_case(7, 7, 1, 1'b1, SENT, "R7 zero taken");
        flag_case(7, 7, 2, 1'b0, 32'd0, "R7 nonzero not taken");
        flag_case(9, 7, 3, 1'b0, 32'd2, "R7 negative not taken");
        flag_case(7, 7, 5, 1'b0, 32'd0, "R7 code 5 never");

        // R7: a load after a zero result leaves the zero flag set.
        clear_mem();
        mem[0] = enc_l(0, 2, 100);
        mem[1] = enc_x(12, 1, 2, 2);
        mem[2] = enc_l(0, 3, 101);
        mem[3] = enc_l(7, 1, 5);
        mem[4] = enc_l(4, 1, 102);
        mem[5] = HALT;
        mem[100] = 32'd7;
        mem[101] = 32'd9;
        run_prog(cyc);
        check("R7 load keeps flags result", mem[102], SENT);
        check("R7 load keeps flags clocks", cyc, 25);

        // R1: sequential immediate loads run in PC order.
        clear_mem();
        mem[0] = enc_d(3, 1, 0, 7);
        mem[1] = enc_d(3, 1, 0, 9);
        mem[2] = enc_l(4, 1, 102);
        mem[3] = HALT;
        run_prog(cyc);
        check("R1 in-order result", mem[102], 32'd9);
        check("R1 in-order clocks", cyc, 18);

        // R4: a single store gives exactly one write strobe.
        clear_mem();
        mem[0] = enc_l(0, 2, 100);
        mem[1] = enc_l(4, 2, 104);
        mem[2] = HALT;
        mem[100] = 32'h0BADF00D;
        run_prog(cyc);
        check("R4 single store data", mem[104], 32'h0BADF00D);
        check("R4 single strobe count", wcnt, 1);
        check("R9 store program clocks", cyc, 16);

        // R10: an unassigned opcode halts in four clocks and then stays idle.
        clear_mem();
        mem[0] = {5'd29, 27'd0};
        mem[1] = enc_l(4, 0, 104);
        run_prog(cyc);
        check("R10 unassigned opcode clocks", cyc, 4);
        held = mem_addr;
        quiet = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mem_we || mem_addr != held || !halted) quiet++;
        end
        check("R10 idle after halt", quiet, 0);
        check("R10 no store after halt", mem[104], SENT);

        // R10: the halt opcode also halts in four clocks.
        clear_mem();
        mem[0] = HALT;
        run_prog(cyc);
        check("R10 halt opcode clocks", cyc, 4);
        check("R10 halted set", halted, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule